// File: doc/BRIEF.md
# Byte-to-Word Host Mailbox

This block is a two-way mailbox between an 8-bit external host port and a 24-bit internal core port. The host builds an outgoing 24-bit word one byte at a time in three byte registers; once the last byte lands, the word is handed to the core as a single receive word. In the opposite direction, the core writes one 24-bit word, which is split into three bytes that the host reads back one at a time.

Each direction has its own empty/full handshake. The two directions never stall each other. Either side can poll its status register. The core can instead take an interrupt that is gated by enable bits in its control register. Each side also owns two general-purpose flag bits in its control register, and those bits show up in the other side's status register.

Everything runs on one clock with a synchronous active-low reset. Read data on both ports is combinational from the addressed register. A read access takes effect on the clock edge where its strobe is sampled.

Top module: `hostMailbox`

## Requirements
- R1: After reset, host status reads 0x02 (transmit-empty = 1, receive-full = 0, flags 0), core status reads 0x000002, all flags are 0 and `coreIrq` is 0.
- R2: Host address map: 0 = host control (flags at bits [4:3]), 1 = host status (bit 0 receive-full, bit 1 transmit-empty, bits [4:3] core flags), 2/3/4 = high/middle/low data byte. Core address map: 0 = core control (bit 0 receive interrupt enable, bit 1 transmit interrupt enable, bits [4:3] flags), 1 = core status (bit 0 receive-full, bit 1 transmit-empty, bits [4:3] host flags), 2 = data word.
- R3: A host write to the low byte completes a word and clears host transmit-empty. If core receive-full is 0, on the next clock the word {high, middle, low} enters the core receive register, core receive-full becomes 1 and host transmit-empty returns to 1.
- R4: While core receive-full is 1, a completed host word waits and host transmit-empty stays 0. Host byte writes made while host transmit-empty is 0 are ignored.
- R5: A core read of address 2 clears core receive-full. A waiting host word then moves in on the following clock.
- R6: A core write to address 2 clears core transmit-empty. If host receive-full is 0, on the next clock the word is split into high = bits [23:16], middle = [15:8] and low = [7:0], host receive-full becomes 1 and core transmit-empty returns to 1.
- R7: A host read of the low byte clears host receive-full. A waiting core word then moves out on the following clock. A core data write made while core transmit-empty is 0 is ignored.
- R8: Core control bits [4:3] appear in host status bits [4:3]. Host control bits [4:3] appear in core status bits [4:3].
- R9: `coreIrq` is 1 exactly when (receive interrupt enable AND core receive-full) OR (transmit interrupt enable AND core transmit-empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| hostSel | input | 1 | Host access strobe, one cycle per access |
| hostWrite | input | 1 | 1 = write, 0 = read during a host access |
| hostAddr | input | 3 | Host register address |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data for the addressed register |
| coreWrEn | input | 1 | Core write strobe |
| coreRdEn | input | 1 | Core read strobe |
| coreAddr | input | 2 | Core register address |
| coreWrData | input | 24 | Core write data |
| coreRdData | output | 24 | Core read data for the addressed register |
| coreIrq | output | 1 | Interrupt request to the core |

## Verification
The bench targets backpressure in both directions. It completes a second word while the first is still unread, then checks two things: the second word stays parked, and a stray byte or word write during the wait does not corrupt it. A design that overwrote pending data would deliver the stray value. A design that dropped the parked word would never raise receive-full again.

The bench checks byte order on both sides, so a swapped lane shows up as a wrong byte value. It checks flag crossing, so a design that mirrored a flag back to its own side would read 0 on the far side. It checks the interrupt against each enable alone, so a design that ignored an enable, or missed the transmit-empty dip after a core write, would show the wrong request level.

// File: rtl/mbxPkg.sv
package mbxPkg;
  localparam int BYTE_W = 8;
  localparam int LANES = 3;
  localparam int WORD_W = BYTE_W * LANES;

  // Strobes from control to datapath; lane 0 = low byte
  typedef struct packed {
    logic [LANES-1:0] hostByteLoad;
    logic             hostCtlLoad;
    logic             coreCtlLoad;
    logic             coreTxLoad;
    logic             moveToCore;
    logic             moveToHost;
  } mbxStrobes_t;
endpackage

// File: rtl/mbxControl.sv
module mbxControl
  import mbxPkg::*;
#(
  parameter int HOST_AW = 3,
  parameter int CORE_AW = 2,
  parameter int HOST_DATA_BASE = 2,
  parameter int CORE_DATA_ADDR = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               coreWrEn,
  input  logic               coreRdEn,
  input  logic [CORE_AW-1:0] coreAddr,
  input  logic [1:0]         coreIrqEn,
  output mbxStrobes_t        strobes,
  output logic               hostRxFull,
  output logic               hostTxEmpty,
  output logic               coreRxFull,
  output logic               coreTxEmpty,
  output logic               coreIrq
);
  localparam int HOST_LOW_ADDR = HOST_DATA_BASE + LANES - 1;

  logic hostTxFullQ, coreRxFullQ, coreTxFullQ, hostRxFullQ;
  logic hostWrAcc, hostRdAcc, hostReadLow, coreReadData;
  logic [LANES-1:0] byteLoad;

  assign hostWrAcc = hostSel & hostWrite;
  assign hostRdAcc = hostSel & ~hostWrite;

  // Lane i (0 = low) sits at HOST_DATA_BASE + LANES-1-i
  for (genvar i = 0; i < LANES; i++) begin : gLaneDecode
    assign byteLoad[i] = hostWrAcc & ~hostTxFullQ &
                         (hostAddr == HOST_AW'(HOST_DATA_BASE + LANES - 1 - i));
  end

  assign hostReadLow  = hostRdAcc & (hostAddr == HOST_AW'(HOST_LOW_ADDR));
  assign coreReadData = coreRdEn & (coreAddr == CORE_AW'(CORE_DATA_ADDR));

  always_comb begin
    strobes.hostByteLoad = byteLoad;
    strobes.hostCtlLoad  = hostWrAcc & (hostAddr == '0);
    strobes.coreCtlLoad  = coreWrEn & (coreAddr == '0);
    strobes.coreTxLoad   = coreWrEn & (coreAddr == CORE_AW'(CORE_DATA_ADDR)) & ~coreTxFullQ;
    strobes.moveToCore   = hostTxFullQ & ~coreRxFullQ;
    strobes.moveToHost   = coreTxFullQ & ~hostRxFullQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostTxFullQ <= 1'b0;
      coreRxFullQ <= 1'b0;
      coreTxFullQ <= 1'b0;
      hostRxFullQ <= 1'b0;
    end else begin
      if (byteLoad[0])              hostTxFullQ <= 1'b1;
      else if (strobes.moveToCore)  hostTxFullQ <= 1'b0;

      if (strobes.moveToCore)       coreRxFullQ <= 1'b1;
      else if (coreReadData)        coreRxFullQ <= 1'b0;

      if (strobes.coreTxLoad)       coreTxFullQ <= 1'b1;
      else if (strobes.moveToHost)  coreTxFullQ <= 1'b0;

      if (strobes.moveToHost)       hostRxFullQ <= 1'b1;
      else if (hostReadLow)         hostRxFullQ <= 1'b0;
    end
  end

  assign hostTxEmpty = ~hostTxFullQ;
  assign hostRxFull  = hostRxFullQ;
  assign coreRxFull  = coreRxFullQ;
  assign coreTxEmpty = ~coreTxFullQ;
  assign coreIrq     = |(coreIrqEn & {coreTxEmpty, coreRxFull});

  // A completed word waiting on a free receive register moves next cycle
  assert_word_to_core_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hostTxFullQ && !coreRxFullQ) |=> (coreRxFullQ && !hostTxFullQ));

  // Pending host word holds while the core has not read
  assert_host_word_waits_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostTxFullQ && coreRxFullQ && !coreReadData) |=> hostTxFullQ);

  // Core receive-full only drops after a core data read
  assert_rx_clear_by_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreRxFullQ) |-> $past(coreReadData));

  // Core word moves to free host bytes next cycle
  assert_word_to_host_R6: assert property (@(posedge clk) disable iff (!rstN)
    (coreTxFullQ && !hostRxFullQ) |=> (hostRxFullQ && !coreTxFullQ));

  // Host receive-full only drops after a low-byte read
  assert_hostrx_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostRxFullQ) |-> $past(hostReadLow));
endmodule

// File: rtl/mbxDatapath.sv
module mbxDatapath
  import mbxPkg::*;
#(
  parameter int HOST_AW = 3,
  parameter int CORE_AW = 2,
  parameter int HOST_DATA_BASE = 2,
  parameter int CORE_DATA_ADDR = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  mbxStrobes_t        strobes,
  input  logic [BYTE_W-1:0]  hostWrData,
  input  logic [WORD_W-1:0]  coreWrData,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [CORE_AW-1:0] coreAddr,
  input  logic               hostRxFull,
  input  logic               hostTxEmpty,
  input  logic               coreRxFull,
  input  logic               coreTxEmpty,
  output logic [1:0]         coreIrqEn,
  output logic [BYTE_W-1:0]  hostRdData,
  output logic [WORD_W-1:0]  coreRdData
);
  logic [LANES-1:0][BYTE_W-1:0] hostTxBytes, hostRxBytes;
  logic [WORD_W-1:0] coreRxWord, coreTxWord, hostTxWord;
  logic [1:0] hostFlags, coreFlags;

  assign hostTxWord = hostTxBytes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostTxBytes <= '0;
      hostRxBytes <= '0;
      coreRxWord  <= '0;
      coreTxWord  <= '0;
      hostFlags   <= '0;
      coreFlags   <= '0;
      coreIrqEn   <= '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (strobes.hostByteLoad[i]) hostTxBytes[i] <= hostWrData;
        if (strobes.moveToHost) hostRxBytes[i] <= coreTxWord[i*BYTE_W +: BYTE_W];
      end
      if (strobes.moveToCore) coreRxWord <= hostTxWord;
      if (strobes.coreTxLoad) coreTxWord <= coreWrData;
      if (strobes.hostCtlLoad) hostFlags <= hostWrData[4:3];
      if (strobes.coreCtlLoad) begin
        coreFlags <= coreWrData[4:3];
        coreIrqEn <= coreWrData[1:0];
      end
    end
  end

  always_comb begin
    hostRdData = '0;
    if (hostAddr == '0)
      hostRdData[4:3] = hostFlags;
    else if (hostAddr == HOST_AW'(1))
      hostRdData[4:0] = {coreFlags, 1'b0, hostTxEmpty, hostRxFull};
    else
      for (int i = 0; i < LANES; i++)
        if (hostAddr == HOST_AW'(HOST_DATA_BASE + LANES - 1 - i))
          hostRdData = hostRxBytes[i];
  end

  always_comb begin
    coreRdData = '0;
    if (coreAddr == '0)
      coreRdData[4:0] = {coreFlags, 1'b0, coreIrqEn};
    else if (coreAddr == CORE_AW'(1))
      coreRdData[4:0] = {hostFlags, 1'b0, coreTxEmpty, coreRxFull};
    else if (coreAddr == CORE_AW'(CORE_DATA_ADDR))
      coreRdData = coreRxWord;
  end

  // Word delivered to the core is the packed host bytes of the prior cycle
  assert_packed_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.moveToCore |=> (coreRxWord == $past(hostTxWord)));

  // Host byte registers stay put while a word is pending
  assert_tx_bytes_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!hostTxEmpty && !strobes.moveToCore) |=> $stable(hostTxBytes));

  // Unpacked host bytes equal the core word of the prior cycle
  assert_unpack_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.moveToHost |=> (hostRxBytes == $past(coreTxWord)));
endmodule

// File: rtl/hostMailbox.sv
module hostMailbox
  import mbxPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSel,
  input  logic        hostWrite,
  input  logic [2:0]  hostAddr,
  input  logic [7:0]  hostWrData,
  output logic [7:0]  hostRdData,
  input  logic        coreWrEn,
  input  logic        coreRdEn,
  input  logic [1:0]  coreAddr,
  input  logic [23:0] coreWrData,
  output logic [23:0] coreRdData,
  output logic        coreIrq
);
  mbxStrobes_t strobes;
  logic hostRxFull, hostTxEmpty, coreRxFull, coreTxEmpty;
  logic [1:0] coreIrqEn;

  mbxControl #(.HOST_AW(3), .CORE_AW(2)) uCtl (
    .clk, .rstN, .hostSel, .hostWrite, .hostAddr,
    .coreWrEn, .coreRdEn, .coreAddr, .coreIrqEn,
    .strobes, .hostRxFull, .hostTxEmpty, .coreRxFull, .coreTxEmpty, .coreIrq
  );

  mbxDatapath #(.HOST_AW(3), .CORE_AW(2)) uDp (
    .clk, .rstN, .strobes, .hostWrData, .coreWrData, .hostAddr, .coreAddr,
    .hostRxFull, .hostTxEmpty, .coreRxFull, .coreTxEmpty,
    .coreIrqEn, .hostRdData, .coreRdData
  );

  // Interrupt never asserted with both enables cleared
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    (coreIrqEn == 2'b00) |-> !coreIrq);
endmodule

// File: tb/hostMailbox_test.sv
`timescale 1ns/1ps
module hostMailbox_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic hostSel = 0, hostWrite = 0;
  logic [2:0] hostAddr = 0;
  logic [7:0] hostWrData = 0, hostRdData;
  logic coreWrEn = 0, coreRdEn = 0;
  logic [1:0] coreAddr = 0;
  logic [23:0] coreWrData = 0, coreRdData;
  logic coreIrq;
  int total = 0, bad = 0;
  logic [23:0] rd;

  always #2.5 clk = ~clk;

  hostMailbox uut (.*);

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); hostSel = 1; hostWrite = 1; hostAddr = a; hostWrData = d;
    @(negedge clk); hostSel = 0; hostWrite = 0;
  endtask

  task automatic hostRd(logic [2:0] a, output logic [23:0] d);
    @(negedge clk); hostSel = 1; hostWrite = 0; hostAddr = a;
    #1 d = {16'h0, hostRdData};
    @(negedge clk); hostSel = 0;
  endtask

  task automatic hostPeek(logic [2:0] a, output logic [23:0] d);
    hostAddr = a; #1 d = {16'h0, hostRdData};
  endtask

  task automatic coreWr(logic [1:0] a, logic [23:0] d);
    @(negedge clk); coreWrEn = 1; coreAddr = a; coreWrData = d;
    @(negedge clk); coreWrEn = 0;
  endtask

  task automatic coreRd(logic [1:0] a, output logic [23:0] d);
    @(negedge clk); coreRdEn = 1; coreAddr = a;
    #1 d = coreRdData;
    @(negedge clk); coreRdEn = 0;
  endtask

  task automatic corePeek(logic [1:0] a, output logic [23:0] d);
    coreAddr = a; #1 d = coreRdData;
  endtask

  task automatic hostWord(logic [23:0] w);
    hostWr(3'd2, w[23:16]); hostWr(3'd3, w[15:8]); hostWr(3'd4, w[7:0]);
  endtask

  task automatic testReset();
    hostPeek(3'd1, rd); check("R1 host status", rd, 24'h02);
    corePeek(2'd1, rd); check("R1 core status", rd, 24'h02);
    corePeek(2'd0, rd); check("R1 core control", rd, 24'h0);
    check("R1 irq", {23'h0, coreIrq}, 24'h0);
  endtask

  task automatic testHostToCore();
    hostWr(3'd2, 8'hA1); hostWr(3'd3, 8'hB2); hostWr(3'd4, 8'hC3);
    hostPeek(3'd1, rd); check("R3 tx-empty clears", rd & 24'h3, 24'h0);
    @(negedge clk);
    hostPeek(3'd1, rd); check("R3 tx-empty returns", rd & 24'h3, 24'h2);
    corePeek(2'd1, rd); check("R3 core rx-full", rd & 24'h3, 24'h3);
    coreRd(2'd2, rd); check("R3 packed word", rd, 24'hA1B2C3);
    corePeek(2'd1, rd); check("R5 rx-full cleared", rd & 24'h1, 24'h0);
  endtask

  task automatic testHostBackpressure();
    hostWord(24'h112233); @(negedge clk);
    hostWord(24'h445566);
    repeat (3) @(negedge clk);
    hostPeek(3'd1, rd); check("R4 word waits", rd & 24'h2, 24'h0);
    hostWr(3'd2, 8'hEE);
    coreRd(2'd2, rd); check("R4 first word intact", rd, 24'h112233);
    @(negedge clk);
    corePeek(2'd1, rd); check("R5 waiting word moves", rd & 24'h1, 24'h1);
    coreRd(2'd2, rd); check("R4 ignored byte write", rd, 24'h445566);
  endtask

  task automatic testCoreToHost();
    coreWr(2'd2, 24'h9A8B7C);
    corePeek(2'd1, rd); check("R6 core tx-empty clears", rd & 24'h2, 24'h0);
    @(negedge clk);
    corePeek(2'd1, rd); check("R6 core tx-empty returns", rd & 24'h2, 24'h2);
    hostPeek(3'd1, rd); check("R6 host rx-full", rd & 24'h1, 24'h1);
    hostRd(3'd2, rd); check("R6 high byte", rd, 24'h9A);
    hostRd(3'd3, rd); check("R6 mid byte", rd, 24'h8B);
    hostRd(3'd4, rd); check("R6 low byte", rd, 24'h7C);
    hostPeek(3'd1, rd); check("R7 rx-full cleared", rd & 24'h1, 24'h0);
  endtask

  task automatic testCoreBackpressure();
    coreWr(2'd2, 24'h010203); @(negedge clk);
    coreWr(2'd2, 24'h040506);
    repeat (2) @(negedge clk);
    corePeek(2'd1, rd); check("R7 core word waits", rd & 24'h2, 24'h0);
    coreWr(2'd2, 24'hDEAD00);
    hostRd(3'd4, rd); check("R7 first low byte", rd, 24'h03);
    @(negedge clk);
    corePeek(2'd1, rd); check("R7 waiting word moved", rd & 24'h2, 24'h2);
    hostRd(3'd2, rd); check("R7 ignored core write", rd, 24'h04);
    hostRd(3'd4, rd); check("R7 second low byte", rd, 24'h06);
  endtask

  task automatic testFlags();
    coreWr(2'd0, 24'h10);
    hostPeek(3'd1, rd); check("R8 core flag to host", rd & 24'h18, 24'h10);
    hostWr(3'd0, 8'h08);
    corePeek(2'd1, rd); check("R8 host flag to core", rd & 24'h18, 24'h08);
    hostPeek(3'd0, rd); check("R2 host control readback", rd, 24'h08);
    coreWr(2'd0, 24'h0);
    hostPeek(3'd1, rd); check("R8 core flag cleared", rd & 24'h18, 24'h0);
  endtask

  task automatic testIrq();
    coreWr(2'd0, 24'h01);
    check("R9 rx enable, rx empty", {23'h0, coreIrq}, 24'h0);
    hostWord(24'h0A0B0C); @(negedge clk);
    check("R9 rx enable, rx full", {23'h0, coreIrq}, 24'h1);
    coreRd(2'd2, rd);
    check("R9 rx read drops irq", {23'h0, coreIrq}, 24'h0);
    coreWr(2'd0, 24'h02);
    check("R9 tx enable, tx empty", {23'h0, coreIrq}, 24'h1);
    coreWr(2'd2, 24'h123456);
    check("R9 tx full drops irq", {23'h0, coreIrq}, 24'h0);
    @(negedge clk);
    check("R9 tx empty again", {23'h0, coreIrq}, 24'h1);
  endtask

  task automatic finishUp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testHostToCore();
    testHostBackpressure();
    testCoreToHost();
    testCoreBackpressure();
    testFlags();
    testIrq();
    finishUp();
  end
endmodule